// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Core

This block is the digital half of a frequency-locked loop that steers an on-chip oscillator to a fixed multiple of a slow, accurate reference (typically a watch crystal). It runs entirely on the oscillator clock. The reference clock enters as an asynchronous input. A two-flop synchronizer and an edge detector mark each rising edge of the reference. A counter measures how many oscillator cycles lie between two consecutive reference edges and compares that figure with the programmed target. The result moves a 10-bit integrator up by one, down by one, or leaves it alone.

The integrator is read as two fields. The upper five bits select a discrete oscillator tap. Only 29 taps exist, so codes 28 to 31 are reported as 28. The lower five bits feed a modulator. Within every 32 oscillator cycles, the modulator requests the next-higher tap on exactly that many cycles and spreads those cycles across the frame with a bit-reversed counter. The analog oscillator takes the tap code and the per-cycle select.

Software supplies the multiplier, the mode bit and the divider field. Setting the multiplier to 31 with the mode bit clear gives the usual start-up target of 32 times the reference. The divider field defaults to D = 2. Asserting the clear input restarts the loop from the lowest tap.

Top module: `fll_core`

## Requirements
- R1: On each detected reference rising edge after the first, the measured period is the number of oscillator cycles since the previous detected edge. The integrator rises by one if this period is below the target, falls by one if it is above the target, and holds if the two are equal. The first edge after reset or clear only arms the measurement.
- R2: With `mode_scale` = 0 the target is `mult_n` + 1, and `div_sel` has no effect.
- R3: With `mode_scale` = 1 the target is (`mult_n` + 1) × 2^`div_sel`, that is D = 1, 2, 4, 8 for `div_sel` = 0, 1, 2, 3.
- R4: The integrator saturates at 0 and at 1023 and never wraps.
- R5: `tap_code` equals integrator bits 9 to 5, except that codes 28 to 31 are output as 28.
- R6: While the integrator is stable and its tap field is below 28, `tap_up` is high on exactly (integrator bits 4 to 0) cycles out of any 32 consecutive oscillator cycles.
- R7: While `tap_code` is 28, `tap_up` stays low.
- R8: Reset and `integ_clr` bring the integrator to 0. Two cycles later `tap_code` is 0 and `tap_up` is 0.
- R9: The integrator changes only in response to a detected reference edge or a clear. With the reference idle it stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; all state runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Reference clock, asynchronous to osc_clk |
| mult_n | input | 7 | Multiplier N |
| mode_scale | input | 1 | 1 multiplies the target by D |
| div_sel | input | 2 | D exponent: D = 2^div_sel |
| integ_clr | input | 1 | Synchronous clear of the integrator and arming |
| tap_code | output | 5 | Selected oscillator tap, clamped to 28 |
| tap_up | output | 1 | Per-cycle request for the next-higher tap |
| integ_q | output | 10 | Integrator value |

## Verification
A wrong step decision or a bad target shows at `integ_q` four oscillator cycles after the reference edge that should have caused it. The error then accumulates, so a run of periods separates correct and faulty behaviour by many counts. A corrupted frame counter or modulation compare shows in the count of `tap_up` over any 32-cycle window while the integrator is still. A missing clamp or wrap shows at the 1023 ceiling, as a tap code above 28 or as a jump back to zero.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic edge_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], ref_i};
        st_d.last = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign edge_o = st_q.sync[SYNC_STAGES-1] & ~st_q.last;

endmodule

// File: rtl/fll_period_cnt.sv
module fll_period_cnt
    import fll_pkg::*;
#(
    parameter int MULT_W = 7,
    parameter int DIV_W  = 2,
    parameter int CNT_W  = 12
) (
    input  logic              osc_clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic              clr_i,
    input  logic [MULT_W-1:0] mult_i,
    input  logic              scale_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              step_vld_o,
    output step_e             step_o
);
    localparam int TGT_W  = MULT_W + (1 << DIV_W);
    localparam int MEAS_W = CNT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             vld;
        step_e            step;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    logic [TGT_W-1:0]  base;
    logic [TGT_W-1:0]  target;
    logic [MEAS_W-1:0] target_ext;
    logic [MEAS_W-1:0] meas;

    always_comb begin
        base       = TGT_W'(mult_i) + TGT_W'(1);
        target     = scale_i ? (base << div_i) : base;
        target_ext = MEAS_W'(target);
        meas       = {1'b0, st_q.cnt} + MEAS_W'(1);

        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.step = STEP_HOLD;

        if (edge_i) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
            if (st_q.armed) begin
                st_d.vld = 1'b1;
                if (meas < target_ext)      st_d.step = STEP_UP;
                else if (meas > target_ext) st_d.step = STEP_DOWN;
                else                        st_d.step = STEP_HOLD;
            end
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (clr_i) begin
            st_d.armed = 1'b0;
            st_d.vld   = 1'b0;
            st_d.step  = STEP_HOLD;
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, armed: 1'b0, vld: 1'b0, step: STEP_HOLD};
        else        st_q <= st_d;
    end

    assign step_vld_o = st_q.vld;
    assign step_o     = st_q.step;

endmodule

// File: rtl/fll_integrator.sv
module fll_integrator
    import fll_pkg::*;
#(
    parameter int INTEG_W = 10
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               step_vld_i,
    input  step_e              step_i,
    output logic [INTEG_W-1:0] integ_o
);
    localparam logic [INTEG_W-1:0] INTEG_MAX = '1;

    typedef struct packed {
        logic [INTEG_W-1:0] val;
    } integ_st_t;

    integ_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.val = '0;
        end else if (step_vld_i) begin
            unique case (step_i)
                STEP_UP:   if (st_q.val != INTEG_MAX) st_d.val = st_q.val + INTEG_W'(1);
                STEP_DOWN: if (st_q.val != '0)        st_d.val = st_q.val - INTEG_W'(1);
                default:   st_d.val = st_q.val;
            endcase
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign integ_o = st_q.val;

endmodule

// File: rtl/fll_modulator.sv
module fll_modulator #(
    parameter int INTEG_W   = 10,
    parameter int TAP_W     = 5,
    parameter int TAP_LIMIT = 28
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic [INTEG_W-1:0] integ_i,
    output logic [TAP_W-1:0]   tap_o,
    output logic               tap_up_o
);
    localparam int MOD_W = INTEG_W - TAP_W;
    localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'(TAP_LIMIT);

    typedef struct packed {
        logic [MOD_W-1:0] frame;
        logic [TAP_W-1:0] tap;
        logic             up;
    } mod_st_t;

    mod_st_t st_d, st_q;

    logic [MOD_W-1:0] frame_rev;
    logic [TAP_W-1:0] tap_field;
    logic [MOD_W-1:0] mod_field;
    logic             at_top;

    for (genvar i = 0; i < MOD_W; i++) begin : g_rev
        assign frame_rev[i] = st_q.frame[MOD_W-1-i];
    end

    always_comb begin
        tap_field = integ_i[INTEG_W-1 -: TAP_W];
        mod_field = integ_i[MOD_W-1:0];
        at_top    = (tap_field >= TAP_TOP);

        st_d       = st_q;
        st_d.frame = st_q.frame + MOD_W'(1);
        st_d.tap   = at_top ? TAP_TOP : tap_field;
        st_d.up    = !at_top && (frame_rev < mod_field);
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_o    = st_q.tap;
    assign tap_up_o = st_q.up;

endmodule

// File: rtl/fll_core.sv
module fll_core
    import fll_pkg::*;
#(
    parameter int INTEG_W     = 10,
    parameter int TAP_W       = 5,
    parameter int TAP_LIMIT   = 28,
    parameter int MULT_W      = 7,
    parameter int DIV_W       = 2,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    input  logic [MULT_W-1:0]  mult_n,
    input  logic               mode_scale,
    input  logic [DIV_W-1:0]   div_sel,
    input  logic               integ_clr,
    output logic [TAP_W-1:0]   tap_code,
    output logic               tap_up,
    output logic [INTEG_W-1:0] integ_q
);
    logic  ref_edge;
    logic  step_vld;
    step_e step_dir;

    fll_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .osc_clk (osc_clk),
        .rst_n   (rst_n),
        .ref_i   (ref_clk),
        .edge_o  (ref_edge)
    );

    fll_period_cnt #(.MULT_W(MULT_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_cnt (
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .edge_i     (ref_edge),
        .clr_i      (integ_clr),
        .mult_i     (mult_n),
        .scale_i    (mode_scale),
        .div_i      (div_sel),
        .step_vld_o (step_vld),
        .step_o     (step_dir)
    );

    fll_integrator #(.INTEG_W(INTEG_W)) u_integ (
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .clr_i      (integ_clr),
        .step_vld_i (step_vld),
        .step_i     (step_dir),
        .integ_o    (integ_q)
    );

    fll_modulator #(.INTEG_W(INTEG_W), .TAP_W(TAP_W), .TAP_LIMIT(TAP_LIMIT)) u_mod (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .integ_i  (integ_q),
        .tap_o    (tap_code),
        .tap_up_o (tap_up)
    );

endmodule

// File: rtl/fll_core_chk.sv
module fll_core_chk #(
    parameter int INTEG_W   = 10,
    parameter int TAP_W     = 5,
    parameter int TAP_LIMIT = 28
) (
    input logic               osc_clk,
    input logic               rst_n,
    input logic               integ_clr,
    input logic               step_vld,
    input logic [INTEG_W-1:0] integ_q,
    input logic [TAP_W-1:0]   tap_code,
    input logic               tap_up
);
    localparam logic [INTEG_W-1:0] IMAX = '1;
    localparam logic [TAP_W-1:0]   TTOP = TAP_W'(TAP_LIMIT);

    AST_STEP_ONE: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !integ_clr |=> (integ_q == $past(integ_q)) || (integ_q == $past(integ_q) + 1'b1)
                    || (integ_q == $past(integ_q) - 1'b1)); // R1
    AST_HOLD_QUIET: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!integ_clr && !step_vld) |=> $stable(integ_q)); // R9
    AST_CLEAR_ZERO: assert property (@(posedge osc_clk) disable iff (!rst_n)
        integ_clr |=> (integ_q == '0)); // R8
    AST_NO_WRAP_TOP: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!integ_clr && integ_q == IMAX) |=> (integ_q != '0)); // R4
    AST_NO_WRAP_BOT: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (!integ_clr && integ_q == '0) |=> (integ_q != IMAX)); // R4
    AST_TAP_CLAMP: assert property (@(posedge osc_clk) disable iff (!rst_n)
        tap_code <= TTOP); // R5
    AST_TOP_NO_MOD: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (tap_code == TTOP) |-> !tap_up); // R7

endmodule

bind fll_core fll_core_chk #(.INTEG_W(INTEG_W), .TAP_W(TAP_W), .TAP_LIMIT(TAP_LIMIT)) u_chk (
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .integ_clr (integ_clr),
    .step_vld  (step_vld),
    .integ_q   (integ_q),
    .tap_code  (tap_code),
    .tap_up    (tap_up)
);

// File: tb/tb_fll_core.sv
module tb_fll_core;

    logic       osc_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       ref_clk = 1'b0;
    logic [6:0] mult_n  = 7'd31;
    logic       mode_scale = 1'b0;
    logic [1:0] div_sel = 2'd1;
    logic       integ_clr = 1'b0;
    logic [4:0] tap_code;
    logic       tap_up;
    logic [9:0] integ_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 osc_clk = ~osc_clk;

    fll_core dut (
        .osc_clk    (osc_clk),
        .rst_n      (rst_n),
        .ref_clk    (ref_clk),
        .mult_n     (mult_n),
        .mode_scale (mode_scale),
        .div_sel    (div_sel),
        .integ_clr  (integ_clr),
        .tap_code   (tap_code),
        .tap_up     (tap_up),
        .integ_q    (integ_q)
    );

    typedef struct packed {
        logic [6:0] n;
        logic       scale;
        logic [1:0] div;
        int         p1;
        int         n1;
        int         p2;
        int         n2;
        int         exp_integ;
    } vec_t;

    // Phase 1 contributes n1 steps, phase 2 contributes n2-1 steps.
    localparam vec_t VECS [6] = '{
        '{7'd31, 1'b0, 2'd1, 24, 8,  32, 4, 8},  // R2 target 32: up 8, hold
        '{7'd15, 1'b1, 2'd1, 16, 10, 48, 5, 6},  // R3 D=2 target 32: up 10, down 4
        '{7'd9,  1'b1, 2'd3, 60, 5, 100, 9, 0},  // R3 D=8 target 80, R4 floor
        '{7'd63, 1'b0, 2'd0, 64, 6,  40, 7, 6},  // R1 hold then up
        '{7'd7,  1'b1, 2'd0, 6,  4,  9,  3, 2},  // R3 D=1 target 8
        '{7'd19, 1'b0, 2'd3, 18, 3,  20, 3, 3}   // R2 div_sel ignored, target 20
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ref_burst(int p, int n);
        for (int i = 0; i < n; i++) begin
            ref_clk = 1'b1;
            repeat (p / 2) @(negedge osc_clk);
            ref_clk = 1'b0;
            repeat (p - p / 2) @(negedge osc_clk);
        end
    endtask

    task automatic count_up(output int c);
        c = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge osc_clk);
            c += int'(tap_up);
        end
    endtask

    task automatic do_clear();
        @(negedge osc_clk);
        integ_clr = 1'b1;
        @(negedge osc_clk);
        integ_clr = 1'b0;
        repeat (4) @(negedge osc_clk);
    endtask

    task automatic set_cfg(logic [6:0] n, logic s, logic [1:0] d);
        mult_n = n;
        mode_scale = s;
        div_sel = d;
    endtask

    initial begin
        int ones;
        repeat (3) @(negedge osc_clk);
        // R8: reset state
        check("R8 reset integ", int'(integ_q), 0);
        check("R8 reset tap_code", int'(tap_code), 0);
        check("R8 reset tap_up", int'(tap_up), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge osc_clk);

        for (int v = 0; v < 6; v++) begin
            set_cfg(VECS[v].n, VECS[v].scale, VECS[v].div);
            do_clear();
            ref_burst(VECS[v].p1, VECS[v].n1);
            ref_burst(VECS[v].p2, VECS[v].n2);
            repeat (8) @(negedge osc_clk);
            check($sformatf("R1 R2 R3 vector %0d integ", v), int'(integ_q), VECS[v].exp_integ);
            count_up(ones);
            check($sformatf("R6 vector %0d tap_up count", v), ones, VECS[v].exp_integ % 32);
        end

        // R9: reference idle leaves the integrator alone
        repeat (100) @(negedge osc_clk);
        check("R9 idle integ", int'(integ_q), VECS[5].exp_integ);

        // R5/R6: integrator 70 -> tap 2, modulation 6
        set_cfg(7'd31, 1'b0, 2'd0);
        do_clear();
        ref_burst(20, 71);
        repeat (8) @(negedge osc_clk);
        check("R1 integ 70", int'(integ_q), 70);
        check("R5 tap_code 2", int'(tap_code), 2);
        count_up(ones);
        check("R6 tap_up count 6", ones, 6);

        // R6: tap 27 still modulates: integrator 876 = 27*32+12
        set_cfg(7'd7, 1'b0, 2'd0);
        do_clear();
        ref_burst(6, 877);
        repeat (8) @(negedge osc_clk);
        check("R1 integ 876", int'(integ_q), 876);
        check("R5 tap_code 27", int'(tap_code), 27);
        count_up(ones);
        check("R6 tap_up count 12", ones, 12);

        // R4/R5/R7: ceiling
        do_clear();
        ref_burst(6, 1030);
        repeat (8) @(negedge osc_clk);
        check("R4 integ ceiling", int'(integ_q), 1023);
        check("R5 tap_code clamp", int'(tap_code), 28);
        count_up(ones);
        check("R7 no modulation at top", ones, 0);

        // R8: clear
        @(negedge osc_clk);
        integ_clr = 1'b1;
        @(negedge osc_clk);
        integ_clr = 1'b0;
        check("R8 clear integ", int'(integ_q), 0);
        repeat (2) @(negedge osc_clk);
        check("R8 clear tap_code", int'(tap_code), 0);
        check("R8 clear tap_up", int'(tap_up), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge osc_clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule